// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a fully associative address translation buffer for a 64-bit virtual address space. Every entry maps one virtual page to one physical page. Each entry has its own power-of-two page size, anywhere from 4 KiB up to 4 GiB, so a single entry can cover a large region. A lookup presents a virtual address, the current address space identifier, an access kind (read, write or execute) and a privilege flag. One cycle later the block returns a hit flag, a fault flag and the translated physical address.

When more than one entry covers the same address, the entry with the smallest page wins. Software can therefore place a small window inside a larger page, for example a 4 KiB hole with other rights or another target inside a 1 GiB mapping. Entries are loaded one at a time through a management write port, and all of them can be invalidated with a single pulse. Each entry keeps a used bit and a dirty bit, which the block sets itself. A read-back port exposes the valid, used and dirty state of any entry so that replacement software can inspect it.

Top module: `vpt_tlb`

## Requirements
- R1: While reset is held and in the first cycle after it, every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all zero.
- R2: An entry matches a lookup only if it is valid, if its identifier equals `lk_asid`, and if its stored page number equals the page number of `lk_vaddr` on every bit at or above its page size. Bits below the page size are not compared.
- R3: The page size field is log2(bytes) minus 12. Code 0 is 4 KiB and code 20 is 4 GiB. An entry whose code is above 20 never matches.
- R4: When several entries match, the one with the smallest size code is selected. If the smallest code is shared, the lowest entry index wins.
- R5: On a hit, `rsp_paddr` takes the selected entry's physical page bits at and above its page size and the bits of `lk_vaddr` below it. When `rsp_hit` is low, `rsp_paddr` is zero.
- R6: The rights are 3 bits, with bit 2 for read, bit 1 for write and bit 0 for execute. The user set applies when `lk_user` is 1 and the supervisor set applies otherwise. `lk_acc` is 0 for read, 1 for write, 2 for execute; 3 is reserved and always denied. A selected entry that is not present, or whose rights deny the access, gives `rsp_fault`=1 and `rsp_hit`=0. The two flags are never high together.
- R7: A lookup that hits sets the selected entry's used bit. A hit with `lk_acc`=1 also sets its dirty bit. A miss or a fault changes neither bit.
- R8: When `mg_wr` is high, the entry at `mg_idx` is replaced in one cycle with the given fields, and its used and dirty bits are cleared. A lookup issued in the next cycle sees the new entry. A lookup issued in the same cycle sees the old contents.
- R9: A pulse on `mg_inval_all` clears the valid bit of every entry at the next clock edge, and it takes precedence over a write in the same cycle.
- R10: `rsp_valid` equals `lk_valid` of the previous cycle. When no lookup was made in the previous cycle, the hit and fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space identifier |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Matching entry not present or access denied |
| rsp_paddr | output | VA_W | Translated physical address |
| mg_wr | input | 1 | Write one entry |
| mg_idx | input | IDX_W | Entry index to write |
| mg_vpn | input | VA_W-12 | Virtual page number |
| mg_ppn | input | VA_W-12 | Physical page number |
| mg_asid | input | ASID_W | Address space identifier of the entry |
| mg_size | input | 5 | Page size code |
| mg_sup_rwx | input | 3 | Supervisor rights |
| mg_usr_rwx | input | 3 | User rights |
| mg_valid | input | 1 | Valid bit to store |
| mg_present | input | 1 | Present bit to store |
| mg_inval_all | input | 1 | Clear every valid bit |
| rd_idx | input | IDX_W | Entry index to read back |
| rd_valid | output | 1 | Valid bit of entry `rd_idx` |
| rd_used | output | 1 | Used bit of entry `rd_idx` |
| rd_dirty | output | 1 | Dirty bit of entry `rd_idx` |

## Verification
The assertions check on every cycle the properties that hold whatever the table contains. The response strobe trails the request by exactly one cycle. Hit and fault are never high together. The address is zero without a hit. An invalidate pulse leaves the read-back entry invalid, and a used bit only goes back to zero through a management write. Other behaviours depend on what the table holds, and only the bench scenarios can show them. These are the smallest-page priority and its lowest-index tie break, nested windows inside large pages, the 4 GiB page and the rejected size codes, the per-mode rights, and the rule that a faulting write leaves the dirty bit clear. The bench covers them with a behavioural model of the table, compared against the block on every clock, in both directed and random traffic.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int RIGHT_R = 2;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 0;

   function automatic logic rights_allow(input logic [2:0] rwx, input acc_e acc);
      logic ok;
      case (acc)
         ACC_READ:  ok = rwx[RIGHT_R];
         ACC_WRITE: ok = rwx[RIGHT_W];
         ACC_EXEC:  ok = rwx[RIGHT_X];
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/vpt_match.sv
module vpt_match #(
   parameter int VPN_W    = 52,
   parameter int ASID_W   = 8,
   parameter int SZ_W     = 5,
   parameter int MAX_CODE = 20
) (
   input  logic              e_valid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [SZ_W-1:0]   e_size,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   output logic              hit
);

   logic [VPN_W-1:0] cmp_mask;
   logic             size_ok;

   always_comb begin
      for (int j = 0; j < VPN_W; j++) begin
         cmp_mask[j] = (j >= int'(e_size));
      end
   end

   assign size_ok = (e_size <= SZ_W'(MAX_CODE));
   assign hit = e_valid && size_ok
                && (((e_vpn ^ q_vpn) & cmp_mask) == '0)
                && ((e_asid ^ q_asid) == '0);

endmodule

// File: rtl/vpt_pick.sv
module vpt_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4,
   parameter int SZ_W  = 5
) (
   input  logic [N-1:0]    hit_vec,
   input  logic [SZ_W-1:0] size_a [N],
   output logic            any,
   output logic [IDX_W-1:0] sel_idx,
   output logic [SZ_W-1:0] sel_size
);

   always_comb begin
      any      = 1'b0;
      sel_idx  = '0;
      sel_size = '1;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i] && (!any || (size_a[i] < sel_size))) begin
            any      = 1'b1;
            sel_idx  = IDX_W'(i);
            sel_size = size_a[i];
         end
      end
   end

endmodule

// File: rtl/vpt_perm.sv
module vpt_perm
   import vpt_pkg::*;
(
   input  logic       present,
   input  logic       user,
   input  logic [2:0] sup_rwx,
   input  logic [2:0] usr_rwx,
   input  logic [1:0] acc,
   output logic       fault
);

   logic [2:0] eff_rwx;

   assign eff_rwx = user ? usr_rwx : sup_rwx;
   assign fault   = !present || !rights_allow(eff_rwx, acc_e'(acc));

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
   import vpt_pkg::*;
#(
   parameter int N         = 16,
   parameter int VA_W      = 64,
   parameter int MIN_SHIFT = 12,
   parameter int ASID_W    = 8,
   parameter int SZ_W      = 5,
   parameter int MAX_CODE  = 20,
   localparam int VPN_W    = VA_W - MIN_SHIFT,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_acc,
   input  logic              lk_user,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic [VA_W-1:0]   rsp_paddr,
   input  logic              mg_wr,
   input  logic [IDX_W-1:0]  mg_idx,
   input  logic [VPN_W-1:0]  mg_vpn,
   input  logic [VPN_W-1:0]  mg_ppn,
   input  logic [ASID_W-1:0] mg_asid,
   input  logic [SZ_W-1:0]   mg_size,
   input  logic [2:0]        mg_sup_rwx,
   input  logic [2:0]        mg_usr_rwx,
   input  logic              mg_valid,
   input  logic              mg_present,
   input  logic              mg_inval_all,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_used,
   output logic              rd_dirty
);

   // elaboration-time parameter checks
   if (N < 2) begin : g_bad_n
      $error("vpt_tlb: N must be at least 2");
   end
   if (MAX_CODE >= VPN_W) begin : g_bad_code
      $error("vpt_tlb: MAX_CODE must be below the page number width");
   end
   if (MAX_CODE >= (1 << SZ_W)) begin : g_bad_szw
      $error("vpt_tlb: SZ_W too narrow for MAX_CODE");
   end
   if (MIN_SHIFT < 1 || MIN_SHIFT >= VA_W) begin : g_bad_shift
      $error("vpt_tlb: MIN_SHIFT out of range");
   end

   // entry storage
   logic              e_valid   [N];
   logic              e_present [N];
   logic              e_used    [N];
   logic              e_dirty   [N];
   logic [VPN_W-1:0]  e_vpn     [N];
   logic [VPN_W-1:0]  e_ppn     [N];
   logic [ASID_W-1:0] e_asid    [N];
   logic [SZ_W-1:0]   e_size    [N];
   logic [2:0]        e_sup     [N];
   logic [2:0]        e_usr     [N];

   logic [VPN_W-1:0]  q_vpn;
   logic [N-1:0]      hit_vec;
   logic              any;
   logic [IDX_W-1:0]  sel_idx;
   logic [SZ_W-1:0]   sel_size;
   logic              sel_fault;
   logic [VA_W-1:0]   xlat;
   logic              do_hit;
   logic              do_fault;

   assign q_vpn = lk_vaddr[VA_W-1:MIN_SHIFT];

   for (genvar g = 0; g < N; g++) begin : g_ent
      vpt_match #(
         .VPN_W    (VPN_W),
         .ASID_W   (ASID_W),
         .SZ_W     (SZ_W),
         .MAX_CODE (MAX_CODE)
      ) u_match (
         .e_valid (e_valid[g]),
         .e_vpn   (e_vpn[g]),
         .e_asid  (e_asid[g]),
         .e_size  (e_size[g]),
         .q_vpn   (q_vpn),
         .q_asid  (lk_asid),
         .hit     (hit_vec[g])
      );
   end

   vpt_pick #(
      .N     (N),
      .IDX_W (IDX_W),
      .SZ_W  (SZ_W)
   ) u_pick (
      .hit_vec  (hit_vec),
      .size_a   (e_size),
      .any      (any),
      .sel_idx  (sel_idx),
      .sel_size (sel_size)
   );

   vpt_perm u_perm (
      .present (e_present[sel_idx]),
      .user    (lk_user),
      .sup_rwx (e_sup[sel_idx]),
      .usr_rwx (e_usr[sel_idx]),
      .acc     (lk_acc),
      .fault   (sel_fault)
   );

   // address composition: page bits above the selected size, offset below
   always_comb begin
      xlat[MIN_SHIFT-1:0] = lk_vaddr[MIN_SHIFT-1:0];
      for (int j = 0; j < VPN_W; j++) begin
         xlat[MIN_SHIFT+j] = (j >= int'(sel_size)) ? e_ppn[sel_idx][j]
                                                   : lk_vaddr[MIN_SHIFT+j];
      end
   end

   assign do_hit   = lk_valid && any && !sel_fault;
   assign do_fault = lk_valid && any && sel_fault;

   // entry state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            e_valid[i]   <= 1'b0;
            e_present[i] <= 1'b0;
            e_used[i]    <= 1'b0;
            e_dirty[i]   <= 1'b0;
            e_vpn[i]     <= '0;
            e_ppn[i]     <= '0;
            e_asid[i]    <= '0;
            e_size[i]    <= '0;
            e_sup[i]     <= '0;
            e_usr[i]     <= '0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            if (mg_wr && (mg_idx == IDX_W'(i))) begin
               e_valid[i]   <= mg_valid;
               e_present[i] <= mg_present;
               e_used[i]    <= 1'b0;
               e_dirty[i]   <= 1'b0;
               e_vpn[i]     <= mg_vpn;
               e_ppn[i]     <= mg_ppn;
               e_asid[i]    <= mg_asid;
               e_size[i]    <= mg_size;
               e_sup[i]     <= mg_sup_rwx;
               e_usr[i]     <= mg_usr_rwx;
            end else if (do_hit && (sel_idx == IDX_W'(i))) begin
               e_used[i] <= 1'b1;
               if (acc_e'(lk_acc) == ACC_WRITE) begin
                  e_dirty[i] <= 1'b1;
               end
            end
            if (mg_inval_all) begin
               e_valid[i] <= 1'b0;
            end
         end
      end
   end

   // registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= do_hit;
         rsp_fault <= do_fault;
         rsp_paddr <= do_hit ? xlat : '0;
      end
   end

   assign rd_valid = e_valid[rd_idx];
   assign rd_used  = e_used[rd_idx];
   assign rd_dirty = e_dirty[rd_idx];

endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
   parameter int VA_W  = 64,
   parameter int IDX_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_fault,
   input logic [VA_W-1:0]   rsp_paddr,
   input logic              mg_wr,
   input logic              mg_inval_all,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              rd_valid,
   input logic              rd_used
);

   p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

   p_hit_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fault));

   p_paddr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_paddr == '0));

   p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mg_inval_all |=> !rd_valid);

   p_used_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_used) && (rd_idx == $past(rd_idx)) && !$past(mg_wr)) |-> rd_used);

endmodule

bind vpt_tlb vpt_tlb_chk #(
   .VA_W  (VA_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_fault    (rsp_fault),
   .rsp_paddr    (rsp_paddr),
   .mg_wr        (mg_wr),
   .mg_inval_all (mg_inval_all),
   .rd_idx       (rd_idx),
   .rd_valid     (rd_valid),
   .rd_used      (rd_used)
);

// File: tb/vpt_tlb_tb_top.sv
`timescale 1ns/100ps
module vpt_tlb_tb_top;

   localparam int N      = 16;
   localparam int VA_W   = 64;
   localparam int VPN_W  = VA_W - 12;
   localparam int ASID_W = 8;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [VA_W-1:0]   lk_vaddr = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic [1:0]        lk_acc = '0;
   logic              lk_user = 1'b0;
   logic              rsp_valid, rsp_hit, rsp_fault;
   logic [VA_W-1:0]   rsp_paddr;
   logic              mg_wr = 1'b0;
   logic [IDX_W-1:0]  mg_idx = '0;
   logic [VPN_W-1:0]  mg_vpn = '0;
   logic [VPN_W-1:0]  mg_ppn = '0;
   logic [ASID_W-1:0] mg_asid = '0;
   logic [4:0]        mg_size = '0;
   logic [2:0]        mg_sup_rwx = '0;
   logic [2:0]        mg_usr_rwx = '0;
   logic              mg_valid = 1'b0;
   logic              mg_present = 1'b0;
   logic              mg_inval_all = 1'b0;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic              rd_valid, rd_used, rd_dirty;

   always #2 clk = ~clk;

   vpt_tlb #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .lk_acc(lk_acc), .lk_user(lk_user),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr),
      .mg_wr(mg_wr), .mg_idx(mg_idx), .mg_vpn(mg_vpn), .mg_ppn(mg_ppn),
      .mg_asid(mg_asid), .mg_size(mg_size), .mg_sup_rwx(mg_sup_rwx),
      .mg_usr_rwx(mg_usr_rwx), .mg_valid(mg_valid), .mg_present(mg_present),
      .mg_inval_all(mg_inval_all),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_used(rd_used), .rd_dirty(rd_dirty)
   );

   int nchk = 0;
   int nerr = 0;
   bit done = 0;
   bit started = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit              m_valid [N];
   bit              m_present [N];
   bit              m_used [N];
   bit              m_dirty [N];
   logic [VPN_W-1:0] m_vpn [N];
   logic [VPN_W-1:0] m_ppn [N];
   logic [7:0]      m_asid [N];
   int              m_size [N];
   logic [2:0]      m_sup [N];
   logic [2:0]      m_usr [N];
   bit              x_rv, x_hit, x_fault;
   logic [63:0]     x_pa;

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0; m_present[i] = 0;
            m_size[i] = 0;
         end
         x_rv = 0; x_hit = 0; x_fault = 0; x_pa = '0;
      end else begin
         int best;
         best = -1;
         x_rv = lk_valid; x_hit = 0; x_fault = 0; x_pa = '0;
         if (lk_valid) begin
            for (int i = 0; i < N; i++) begin
               bit ok;
               ok = m_valid[i] && (m_size[i] <= 20) && (m_asid[i] == lk_asid);
               for (int j = m_size[i]; j < VPN_W; j++)
                  if (m_vpn[i][j] != lk_vaddr[12+j]) ok = 0;
               if (ok && (best < 0 || m_size[i] < m_size[best])) best = i;
            end
            if (best >= 0) begin
               logic [2:0] r;
               bit allow;
               r = lk_user ? m_usr[best] : m_sup[best];
               allow = (lk_acc == 0) ? r[2] : (lk_acc == 1) ? r[1] :
                       (lk_acc == 2) ? r[0] : 1'b0;
               if (!m_present[best] || !allow) x_fault = 1;
               else begin
                  x_hit = 1;
                  x_pa = lk_vaddr;
                  for (int j = m_size[best]; j < VPN_W; j++) x_pa[12+j] = m_ppn[best][j];
                  m_used[best] = 1;
                  if (lk_acc == 1) m_dirty[best] = 1;
               end
            end
         end
         if (mg_wr) begin
            m_valid[mg_idx] = mg_valid; m_present[mg_idx] = mg_present;
            m_used[mg_idx] = 0; m_dirty[mg_idx] = 0;
            m_vpn[mg_idx] = mg_vpn; m_ppn[mg_idx] = mg_ppn; m_asid[mg_idx] = mg_asid;
            m_size[mg_idx] = int'(mg_size);
            m_sup[mg_idx] = mg_sup_rwx; m_usr[mg_idx] = mg_usr_rwx;
         end
         if (mg_inval_all)
            for (int i = 0; i < N; i++) m_valid[i] = 0;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         chk(rsp_valid === x_rv,    "R10 rsp_valid", 64'(rsp_valid), 64'(x_rv));
         chk(rsp_hit === x_hit,     "R2 rsp_hit",    64'(rsp_hit),   64'(x_hit));
         chk(rsp_fault === x_fault, "R6 rsp_fault",  64'(rsp_fault), 64'(x_fault));
         chk(rsp_paddr === x_pa,    "R5 rsp_paddr",  rsp_paddr,      x_pa);
         chk(rd_valid === m_valid[rd_idx], "R9 rd_valid", 64'(rd_valid), 64'(m_valid[rd_idx]));
         chk(rd_used === m_used[rd_idx],   "R7 rd_used",  64'(rd_used),  64'(m_used[rd_idx]));
         chk(rd_dirty === m_dirty[rd_idx], "R7 rd_dirty", 64'(rd_dirty), 64'(m_dirty[rd_idx]));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_entry(input int idx, input logic [63:0] va, input logic [63:0] pa,
                           input int sz, input logic [2:0] sup, input logic [2:0] usr,
                           input bit pres);
      mg_wr = 1; mg_idx = IDX_W'(idx); mg_vpn = va[63:12]; mg_ppn = pa[63:12];
      mg_asid = 8'd5; mg_size = 5'(sz); mg_sup_rwx = sup; mg_usr_rwx = usr;
      mg_valid = 1; mg_present = pres;
      step();
      mg_wr = 0;
   endtask

   task automatic look(input logic [63:0] va, input logic [7:0] asid,
                       input logic [1:0] acc, input bit usr);
      lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_acc = acc; lk_user = usr;
      step();
      lk_valid = 0;
   endtask

   task automatic expect_rsp(input bit h, input bit f, input logic [63:0] pa,
                             input string tag);
      chk(rsp_hit === h,    {tag, " hit"},   64'(rsp_hit),   64'(h));
      chk(rsp_fault === f,  {tag, " fault"}, 64'(rsp_fault), 64'(f));
      chk(rsp_paddr === pa, {tag, " paddr"}, rsp_paddr,      pa);
   endtask

   task automatic expect_rd(input int idx, input bit v, input bit u, input bit d,
                            input string tag);
      rd_idx = IDX_W'(idx);
      #0.5;
      chk(rd_valid === v, {tag, " valid"}, 64'(rd_valid), 64'(v));
      chk(rd_used === u,  {tag, " used"},  64'(rd_used),  64'(u));
      chk(rd_dirty === d, {tag, " dirty"}, 64'(rd_dirty), 64'(d));
   endtask

   initial begin
      repeat (3) step();
      // R1: reset state
      expect_rsp(0, 0, 64'h0, "R1 reset");
      chk(rsp_valid === 0, "R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
      for (int i = 0; i < N; i++) expect_rd(i, 0, 0, 0, "R1 reset entry");
      rst_n = 1;
      step();
      expect_rsp(0, 0, 64'h0, "R1 after reset");

      // 1 GiB page (code 18), user R-X
      wr_entry(0, 64'h4000_0000, 64'h8000_0000, 18, 3'b111, 3'b101, 1);
      look(64'h4123_4567, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h8123_4567, "R2 R5 big page");
      look(64'h4123_4567, 8'd6, 2'd0, 1);
      expect_rsp(0, 0, 64'h0, "R2 asid mismatch");

      // 4 KiB window and 2 MiB window inside the 1 GiB page
      wr_entry(3, 64'h4020_0000, 64'h1234_5000, 0, 3'b111, 3'b110, 1);
      wr_entry(7, 64'h4020_0000, 64'h6000_0000, 9, 3'b111, 3'b111, 1);
      look(64'h4020_0abc, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h1234_5abc, "R4 smallest window");
      look(64'h4021_0010, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h6001_0010, "R4 middle window");
      look(64'h4050_0000, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h8050_0000, "R4 outer page");
      // tie: same size code at a higher index loses
      wr_entry(9, 64'h4020_0000, 64'h7777_7000, 0, 3'b111, 3'b111, 1);
      look(64'h4020_0abc, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h1234_5abc, "R4 tie lowest index");

      // R6 permissions
      look(64'h4020_0abc, 8'd5, 2'd2, 1);
      expect_rsp(0, 1, 64'h0, "R6 user exec denied");
      look(64'h4020_0abc, 8'd5, 2'd2, 0);
      expect_rsp(1, 0, 64'h1234_5abc, "R6 supervisor exec");
      look(64'h4100_0000, 8'd5, 2'd1, 1);
      expect_rsp(0, 1, 64'h0, "R6 user write denied");
      expect_rd(0, 1, 1, 0, "R7 fault leaves dirty");
      look(64'h4100_0000, 8'd5, 2'd3, 0);
      expect_rsp(0, 1, 64'h0, "R6 reserved access");
      wr_entry(12, 64'h9000_0000, 64'h3000_0000, 0, 3'b111, 3'b111, 0);
      look(64'h9000_0010, 8'd5, 2'd0, 0);
      expect_rsp(0, 1, 64'h0, "R6 not present");
      expect_rd(12, 1, 0, 0, "R7 fault leaves used");

      // R3 size codes
      wr_entry(13, 64'h0, 64'h5000_0000, 21, 3'b111, 3'b111, 1);
      look(64'h0000_0040, 8'd5, 2'd0, 0);
      expect_rsp(0, 0, 64'h0, "R3 code 21 rejected");
      wr_entry(14, 64'h1_0000_0000, 64'h2_0000_0000, 20, 3'b111, 3'b111, 1);
      expect_rd(14, 1, 0, 0, "R7 fresh entry");
      look(64'h1_ffff_fff0, 8'd5, 2'd0, 0);
      expect_rsp(1, 0, 64'h2_ffff_fff0, "R3 4 GiB page");
      expect_rd(14, 1, 1, 0, "R7 read sets used");
      look(64'h1_0000_0008, 8'd5, 2'd1, 0);
      expect_rd(14, 1, 1, 1, "R7 write sets dirty");

      // R8 rewrite
      wr_entry(3, 64'h4020_0000, 64'h5555_5000, 0, 3'b111, 3'b111, 1);
      expect_rd(3, 1, 0, 0, "R8 rewrite clears bits");
      look(64'h4020_0abc, 8'd5, 2'd0, 1);
      expect_rsp(1, 0, 64'h5555_5abc, "R8 new mapping");

      // R9 invalidate all
      mg_inval_all = 1; step(); mg_inval_all = 0;
      look(64'h4123_4567, 8'd5, 2'd0, 0);
      expect_rsp(0, 0, 64'h0, "R9 after invalidate");
      for (int i = 0; i < N; i++) expect_rd(i, 0, m_used[i], m_dirty[i], "R9 entry");

      // random traffic against the model
      for (int k = 0; k < 3000; k++) begin
         logic [63:0] base;
         int sel;
         sel = int'($urandom % 4);
         base = (sel == 0) ? 64'h4000_0000 : (sel == 1) ? 64'h4020_0000 :
                (sel == 2) ? 64'h1_0000_0000 : 64'h9000_0000;
         rd_idx = IDX_W'($urandom);
         lk_valid = ($urandom % 3) != 0;
         lk_vaddr = base + 64'($urandom % 32'h0040_0000);
         lk_asid = ($urandom % 5 == 0) ? 8'd6 : 8'd5;
         lk_acc = 2'($urandom);
         lk_user = 1'($urandom);
         mg_wr = ($urandom % 6) == 0;
         mg_idx = IDX_W'($urandom);
         mg_vpn = base[63:12];
         mg_ppn = 52'($urandom);
         mg_asid = ($urandom % 5 == 0) ? 8'd6 : 8'd5;
         mg_size = 5'($urandom % 23);
         mg_sup_rwx = 3'($urandom);
         mg_usr_rwx = 3'($urandom);
         mg_valid = ($urandom % 8) != 0;
         mg_present = ($urandom % 8) != 0;
         mg_inval_all = ($urandom % 200) == 0;
         step();
      end
      lk_valid = 0; mg_wr = 0; mg_inval_all = 0;
      step(); step();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nerr++;
         $display("FAIL watchdog R10: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule